// File: doc/BRIEF.md
# Branch Queue Refill Sequencer

This block steps the instruction prefetch queue through one branch instruction. A decode stage pulses `start` and supplies four things: whether the branch is a short or a long (prebyte-prefixed) form, whether its condition holds, whether the one-byte prebyte sits on an odd address, and two word addresses. The first address is the resolved destination. The second is the next in-line program word.

From the cycle after it accepts a branch, the block emits one bus-cycle code per clock, up to four cycles in all. Each code is a program word fetch or a free cycle. A flag marks the cycles that are optional fetches, whose final kind depends on the prebyte alignment. Alongside the codes, the block drives a fetch request with its word address, a queue flush strobe, a queue advance strobe and a done pulse.

A taken branch empties the queue and refills it with three consecutive words starting at the destination. A branch that is not taken keeps the in-line stream going. Address arithmetic for the destination, opcode decoding and the queue storage are handled elsewhere.

Top module: `brq_refill_seq`

## Requirements
- R1: Out of reset and between sequences, `busy`, `cyc_opt`, `fetch_req`, `q_flush`, `q_advance` and `done` are low and `cyc_code` is 0 (no cycle). `cyc_code` values: 0 = no cycle, 1 = program word fetch, 2 = free cycle.
- R2: `start` is accepted only while `busy` is low. On acceptance, the branch inputs and both addresses are captured, and the sequence occupies the following clock cycles. While `busy` is high, `start` and the other inputs have no effect on the running sequence, and no new sequence follows it.
- R3: A short taken branch lasts 3 cycles, all program fetches, at the destination address, then +2, then +4.
- R4: A short branch that is not taken lasts 1 cycle: one program fetch at the in-line address.
- R5: A long taken branch lasts 4 cycles. The first is an optional cycle, followed by three program fetches at the destination address, then +2, then +4.
- R6: A long branch that is not taken lasts 3 cycles: optional, program fetch, optional. Each fetch it actually makes uses the in-line address, and each later fetch uses the address 2 above the previous one.
- R7: In an optional cycle `cyc_opt` is high. If the prebyte is misaligned, the cycle is a program fetch (code 1, `fetch_req` high). If the prebyte is aligned, it is a free cycle (code 2, `fetch_req` low).
- R8: `q_flush` is high in exactly one cycle of a taken branch: the cycle of the first refill fetch. It is never high for a branch that is not taken.
- R9: `q_advance` is high in every cycle of a branch that is not taken and in the prebyte cycle of a long taken branch, and low otherwise.
- R10: `done` is high only in the last cycle of a sequence. In the next cycle `busy` is low.
- R11: Fetch addresses wrap modulo 2^ADDR_W.
- R12: An active-low synchronous reset during a sequence returns the block to the idle state of R1 at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a branch sequence (taken only when idle) |
| br_long | input | 1 | 1 = long branch with prebyte, 0 = short branch |
| br_taken | input | 1 | Branch condition result |
| pre_misaligned | input | 1 | Prebyte lies on an odd address |
| target_addr | input | ADDR_W | Resolved destination word address |
| inline_addr | input | ADDR_W | Next in-line program word address |
| busy | output | 1 | A sequence is running |
| cyc_code | output | 2 | Cycle kind: 0 none, 1 program fetch, 2 free |
| cyc_opt | output | 1 | Current cycle is an optional (alignment-resolved) cycle |
| fetch_req | output | 1 | Fetch a program word this cycle |
| fetch_addr | output | ADDR_W | Word address of the fetch |
| q_flush | output | 1 | Discard the queue contents |
| q_advance | output | 1 | Shift the queue by one entry |
| done | output | 1 | Last cycle of the sequence |

## Verification
The hardest situation to reach from the ports is a new `start` that arrives, with different inputs, while a sequence is part-way through. A correct block must keep the captured branch kind and pointers and must not chain a second sequence. The stimulus raises `start` together with altered branch inputs and addresses in the second cycle of a long taken branch. The bench then checks every remaining step against the original pattern and confirms an idle cycle afterwards. Address wrap is reached by placing the destination and in-line addresses just below the top of the address space, so that the +2 steps cross zero.

// File: rtl/brq_pkg.sv
// Shared definitions for the branch queue refill sequencer.
// Assumes sequences never exceed MAX_STEPS cycles.
package brq_pkg;
    localparam int MAX_STEPS = 4;
    localparam int STEP_W    = $clog2(MAX_STEPS);

    typedef enum logic [1:0] {
        CYC_NONE = 2'd0,
        CYC_PROG = 2'd1,
        CYC_FREE = 2'd2
    } cyc_t;
endpackage

// File: rtl/brq_step_ctrl.sv
// Step controller: accepts a branch when idle, captures its kind and
// counts the cycles of its sequence. Assumes start is ignored while active.
module brq_step_ctrl
    import brq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              br_long,
    input  logic              br_taken,
    input  logic              pre_misaligned,
    output logic              load,
    output logic              active,
    output logic [STEP_W-1:0] step,
    output logic              long_q,
    output logic              taken_q,
    output logic              mis_q,
    output logic              last
);
    logic [STEP_W-1:0] last_idx;

    // Acceptance only from idle.
    assign load = start && !active;

    // Index of the final cycle for each branch kind.
    always_comb begin
        if (long_q) last_idx = taken_q ? STEP_W'(3) : STEP_W'(2);
        else        last_idx = taken_q ? STEP_W'(2) : STEP_W'(0);
    end

    assign last = active && (step == last_idx);

    // Sequence state: capture on load, step until the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            step    <= '0;
            long_q  <= 1'b0;
            taken_q <= 1'b0;
            mis_q   <= 1'b0;
        end else if (load) begin
            active  <= 1'b1;
            step    <= '0;
            long_q  <= br_long;
            taken_q <= br_taken;
            mis_q   <= pre_misaligned;
        end else if (active) begin
            if (last) begin
                active <= 1'b0;
                step   <= '0;
            end else begin
                step <= step + STEP_W'(1);
            end
        end
    end
endmodule

// File: rtl/brq_cycle_decode.sv
// Cycle decoder: maps the captured branch kind and step number to the
// cycle code and queue strobes. Purely combinational.
module brq_cycle_decode
    import brq_pkg::*;
(
    input  logic              active,
    input  logic [STEP_W-1:0] step,
    input  logic              long_q,
    input  logic              taken_q,
    input  logic              mis_q,
    output cyc_t              cyc_code,
    output logic              cyc_opt,
    output logic              fetch_req,
    output logic              use_refill,
    output logic              q_flush,
    output logic              q_advance
);
    logic inline_prog;
    logic first_refill;

    // Classify the current step and derive the strobes.
    always_comb begin
        cyc_opt      = active && long_q &&
                       ((step == STEP_W'(0)) || (!taken_q && step == STEP_W'(2)));
        use_refill   = active && taken_q && (!long_q || step != STEP_W'(0));
        inline_prog  = active && !taken_q && !cyc_opt;
        fetch_req    = use_refill || inline_prog || (cyc_opt && mis_q);
        first_refill = long_q ? (step == STEP_W'(1)) : (step == STEP_W'(0));
        q_flush      = use_refill && first_refill;
        q_advance    = active && (!taken_q || cyc_opt);
        if (!active)        cyc_code = CYC_NONE;
        else if (fetch_req) cyc_code = CYC_PROG;
        else                cyc_code = CYC_FREE;
    end
endmodule

// File: rtl/brq_addr_gen.sv
// Address generator: keeps a destination pointer and an in-line pointer,
// each stepping by one word after it is used. Wraps modulo 2^ADDR_W.
module brq_addr_gen #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] target_addr,
    input  logic [ADDR_W-1:0] inline_addr,
    input  logic              fetch_req,
    input  logic              use_refill,
    output logic [ADDR_W-1:0] fetch_addr
);
    localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(2);

    logic [ADDR_W-1:0] tgt_ptr;
    logic [ADDR_W-1:0] seq_ptr;

    // Select the pointer feeding this cycle's fetch.
    assign fetch_addr = use_refill ? tgt_ptr : seq_ptr;

    // Load both pointers on acceptance; bump the one used by a fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_ptr <= '0;
            seq_ptr <= '0;
        end else if (load) begin
            tgt_ptr <= target_addr;
            seq_ptr <= inline_addr;
        end else if (fetch_req) begin
            if (use_refill) tgt_ptr <= tgt_ptr + WORD_STEP;
            else            seq_ptr <= seq_ptr + WORD_STEP;
        end
    end
endmodule

// File: rtl/brq_refill_seq.sv
// Top of the branch queue refill sequencer. Joins the step controller,
// the cycle decoder and the address generator. Assumes target_addr and
// inline_addr are valid in the cycle start is accepted.
module brq_refill_seq
    import brq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              br_long,
    input  logic              br_taken,
    input  logic              pre_misaligned,
    input  logic [ADDR_W-1:0] target_addr,
    input  logic [ADDR_W-1:0] inline_addr,
    output logic              busy,
    output logic [1:0]        cyc_code,
    output logic              cyc_opt,
    output logic              fetch_req,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              q_flush,
    output logic              q_advance,
    output logic              done
);
    logic              load;
    logic              active;
    logic [STEP_W-1:0] step;
    logic              long_q;
    logic              taken_q;
    logic              mis_q;
    logic              last;
    logic              use_refill;
    cyc_t              code;

    brq_step_ctrl u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .start          (start),
        .br_long        (br_long),
        .br_taken       (br_taken),
        .pre_misaligned (pre_misaligned),
        .load           (load),
        .active         (active),
        .step           (step),
        .long_q         (long_q),
        .taken_q        (taken_q),
        .mis_q          (mis_q),
        .last           (last)
    );

    brq_cycle_decode u_dec (
        .active     (active),
        .step       (step),
        .long_q     (long_q),
        .taken_q    (taken_q),
        .mis_q      (mis_q),
        .cyc_code   (code),
        .cyc_opt    (cyc_opt),
        .fetch_req  (fetch_req),
        .use_refill (use_refill),
        .q_flush    (q_flush),
        .q_advance  (q_advance)
    );

    brq_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .target_addr (target_addr),
        .inline_addr (inline_addr),
        .fetch_req   (fetch_req),
        .use_refill  (use_refill),
        .fetch_addr  (fetch_addr)
    );

    // Port-level views of the controller state.
    assign busy     = active;
    assign done     = last;
    assign cyc_code = code;
endmodule

// File: rtl/brq_refill_chk.sv
// Checker for brq_refill_seq: temporal properties on its ports,
// attached with the bind at the end of this file.
module brq_refill_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              br_long,
    input logic              br_taken,
    input logic              pre_misaligned,
    input logic [ADDR_W-1:0] target_addr,
    input logic [ADDR_W-1:0] inline_addr,
    input logic              busy,
    input logic [1:0]        cyc_code,
    input logic              cyc_opt,
    input logic              fetch_req,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              q_flush,
    input logic              q_advance,
    input logic              done
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cyc_code == 2'd0 && !fetch_req && !q_flush && !q_advance && !done));

    // R2
    accept_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && cyc_opt == $past(br_long)));

    // R2
    hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R10
    done_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R8
    refill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && fetch_req && $past(busy) && $past(q_flush))
            |-> fetch_addr == $past(fetch_addr) + ADDR_W'(2));

    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({q_flush, q_advance}));

    // R7
    opt_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_opt |-> (cyc_code == 2'd1 || cyc_code == 2'd2));
endmodule

bind brq_refill_seq brq_refill_chk #(.ADDR_W(ADDR_W)) u_brq_chk (.*);

// File: tb/test_brq_refill_seq.sv
`timescale 1ns/1ps
// Bench for brq_refill_seq: a vector table walked by one loop, then
// directed tests for reset, a start while busy and a mid-sequence reset.
module test_brq_refill_seq;
    localparam int AW = 16;

    typedef struct packed {
        logic          lng;
        logic          tkn;
        logic          mis;
        logic [AW-1:0] tgt;
        logic [AW-1:0] inl;
        logic [2:0]    len;
        logic [7:0]    codes;   // step k at bits [2k+1:2k]
        logic [3:0]    opts;    // step k at bit k
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b1, 1'b0, 16'h1200, 16'h0040, 3'd3, 8'h15, 4'b0000},
        '{1'b0, 1'b1, 1'b1, 16'hFFFC, 16'h0100, 3'd3, 8'h15, 4'b0000},
        '{1'b0, 1'b0, 1'b0, 16'h2000, 16'h0302, 3'd1, 8'h01, 4'b0000},
        '{1'b0, 1'b0, 1'b1, 16'h2000, 16'h0500, 3'd1, 8'h01, 4'b0000},
        '{1'b1, 1'b1, 1'b1, 16'h3400, 16'h0600, 3'd4, 8'h55, 4'b0001},
        '{1'b1, 1'b1, 1'b0, 16'h4560, 16'h0700, 3'd4, 8'h56, 4'b0001},
        '{1'b1, 1'b0, 1'b1, 16'h5000, 16'hFFFE, 3'd3, 8'h15, 4'b0101},
        '{1'b1, 1'b0, 1'b0, 16'h5000, 16'h0810, 3'd3, 8'h26, 4'b0101},
        '{1'b1, 1'b1, 1'b0, 16'hFFFE, 16'h0900, 3'd4, 8'h56, 4'b0001}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          br_long = 1'b0;
    logic          br_taken = 1'b0;
    logic          pre_misaligned = 1'b0;
    logic [AW-1:0] target_addr = '0;
    logic [AW-1:0] inline_addr = '0;
    logic          busy;
    logic [1:0]    cyc_code;
    logic          cyc_opt;
    logic          fetch_req;
    logic [AW-1:0] fetch_addr;
    logic          q_flush;
    logic          q_advance;
    logic          done;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    brq_refill_seq #(.ADDR_W(AW)) i_brq_refill_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .start          (start),
        .br_long        (br_long),
        .br_taken       (br_taken),
        .pre_misaligned (pre_misaligned),
        .target_addr    (target_addr),
        .inline_addr    (inline_addr),
        .busy           (busy),
        .cyc_code       (cyc_code),
        .cyc_opt        (cyc_opt),
        .fetch_req      (fetch_req),
        .fetch_addr     (fetch_addr),
        .q_flush        (q_flush),
        .q_advance      (q_advance),
        .done           (done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // R1: all outputs quiet.
    task automatic check_idle(input string tag);
        check(busy == 1'b0, "R1", {tag, " busy"}, int'(busy), 0);
        check(cyc_code == 2'd0, "R1", {tag, " code"}, int'(cyc_code), 0);
        check({cyc_opt, fetch_req, q_flush, q_advance, done} == 5'b0, "R1",
              {tag, " strobes"}, int'({cyc_opt, fetch_req, q_flush, q_advance, done}), 0);
    endtask

    // Run one branch; with poke, raise start with other inputs at step 1 (R2).
    task automatic run_seq(input vec_t v, input bit poke);
        int refill_n = 0;
        int inl_n = 0;
        @(negedge clk);
        br_long = v.lng; br_taken = v.tkn; pre_misaligned = v.mis;
        target_addr = v.tgt; inline_addr = v.inl; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < int'(v.len); k++) begin
            logic [1:0] ec;
            bit refill;
            bit fetch;
            logic [AW-1:0] ea;
            ec = v.codes[2*k +: 2];
            refill = v.tkn && (!v.lng || k > 0);
            fetch = (ec == 2'd1);
            ea = refill ? v.tgt + AW'(2 * refill_n) : v.inl + AW'(2 * inl_n);
            check(busy == 1'b1, "R2", "busy in sequence", int'(busy), 1);
            check(cyc_code == ec, v.lng ? (v.tkn ? "R5" : "R6") : (v.tkn ? "R3" : "R4"),
                  $sformatf("code step %0d", k), int'(cyc_code), int'(ec));
            check(cyc_opt == v.opts[k], "R7", $sformatf("opt step %0d", k),
                  int'(cyc_opt), int'(v.opts[k]));
            check(fetch_req == fetch, "R7", $sformatf("fetch_req step %0d", k),
                  int'(fetch_req), int'(fetch));
            if (fetch) begin
                check(fetch_addr == ea, "R11", $sformatf("addr step %0d", k),
                      int'(fetch_addr), int'(ea));
                if (refill) refill_n++; else inl_n++;
            end
            check(q_flush == (v.tkn && k == (v.lng ? 1 : 0)), "R8",
                  $sformatf("flush step %0d", k), int'(q_flush),
                  int'(v.tkn && k == (v.lng ? 1 : 0)));
            check(q_advance == (!v.tkn || (v.lng && k == 0)), "R9",
                  $sformatf("advance step %0d", k), int'(q_advance),
                  int'(!v.tkn || (v.lng && k == 0)));
            check(done == (k == int'(v.len) - 1), "R10", $sformatf("done step %0d", k),
                  int'(done), int'(k == int'(v.len) - 1));
            if (poke && k == 1) begin
                start = 1'b1; br_long = ~v.lng; br_taken = ~v.tkn;
                pre_misaligned = ~v.mis; target_addr = 16'hAAAA; inline_addr = 16'h5554;
            end
            @(negedge clk);
            start = 1'b0;
        end
        check_idle("after sequence R10");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_idle("reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("after reset");

        for (int i = 0; i < NVEC; i++) run_seq(VECS[i], 1'b0);

        // R2: start with altered inputs while busy has no effect.
        run_seq(VECS[4], 1'b1);
        run_seq(VECS[6], 1'b1);

        // R12: reset in the middle of a long taken branch.
        @(negedge clk);
        br_long = 1'b1; br_taken = 1'b1; pre_misaligned = 1'b1;
        target_addr = 16'h0A00; inline_addr = 16'h0B00; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        check(busy == 1'b1, "R12", "busy before reset", int'(busy), 1);
        rst_n = 1'b0;
        @(negedge clk);
        check(busy == 1'b0 && cyc_code == 2'd0, "R12", "idle after reset",
              int'({busy, cyc_code}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R12 settle");
        run_seq(VECS[0], 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule